// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execution Unit

This unit carries out the second half of a two-byte instruction class in an 8-bit processor: eight shift/rotate kinds plus bit test, bit clear and bit set. It is started once the prefix byte has been seen. It then reads the following opcode byte from the program counter address and reports the incremented program counter. It splits that byte into an operation group, a sub-field (shift kind or bit index) and an operand select. The operand is either a register of the surrounding CPU's register file or the memory byte addressed by the HL pair.

Register operands are read and written through a small select/data port. Flags are taken from and returned to the CPU's flag byte. Memory is reached through a byte-wide port with separate read and write strobes and a shared ready input. Every instruction has a cycle budget that depends on its class. The unit raises a one-cycle done pulse when that budget has elapsed and presents the budget on a count output.

The controller is a single state machine with six states:
- IDLE waits for start.
- FETCH reads the opcode.
- MREAD reads the memory operand.
- OPER computes the result and writes register and flags.
- MWRITE stores a modified memory byte.
- HOLD waits out the remaining budget.

Its transitions are:
- IDLE to FETCH on start.
- FETCH to MREAD on ready when the operand is memory, or FETCH to OPER on ready for a register operand.
- MREAD to OPER on ready.
- OPER to MWRITE for a memory operand in any group except test, otherwise OPER to HOLD.
- MWRITE to HOLD on ready.
- HOLD to IDLE once the elapsed count reaches the budget, which is the cycle done is high.

Top module: `bitop_unit`

## Requirements
- R1: After reset the unit is idle: busy, done, mem_rd, mem_wr, rf_we, flags_we and pc_we are all low.
- R2: A start accepted while idle causes a read at pc_in. The transfer that completes it raises pc_we for one cycle with pc_out equal to pc_in plus one.
- R3: Opcode bits [2:0] choose the operand: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory at HL, 7 A. The value appears on rf_sel for register operands, and no other register is written.
- R4: When bits [7:6] are 00, bits [5:3] choose the shift kind and the stored result follows it:
  - 0 rotates left with bit 7 wrapping into bit 0.
  - 1 rotates right with bit 0 wrapping into bit 7.
  - 2 rotates left through carry.
  - 3 rotates right through carry.
  - 4 shifts left with 0 entering.
  - 5 shifts right keeping bit 7.
  - 6 shifts left with 1 entering.
  - 7 shifts right with 0 entering.
- R5: For the shift group, the flag byte is updated as follows:
  - sign (bit 7) copies result bit 7.
  - zero (bit 6) is set for a zero result.
  - parity (bit 2) is set when the result has an even number of ones.
  - carry (bit 0) takes the bit shifted out.
  - half-carry (bit 4) and subtract (bit 1) are cleared.
  - bits 5 and 3 are kept.
- R6: When bits [7:6] are 01, bit [5:3] of the operand is tested and the operand is left unchanged. Zero is set to the inverse of the tested bit, half-carry is set and subtract is cleared. Sign equals the tested bit when the index is 7 and is cleared otherwise. Carry, parity and bits 5 and 3 are kept.
- R7: When bits [7:6] are 10 the indexed bit is cleared, and when they are 11 it is set. In both cases flags_we stays low.
- R8: With a register operand and a memory that answers at once, the result is written through rf_we in a single cycle and done is high in the 8th cycle after the start cycle.
- R9: A memory-operand shift, clear or set reads HL and writes the new byte once at HL, with done in the 15th cycle.
- R10: A memory-operand bit test reads HL, performs no write, and raises done in the 12th cycle.
- R11: A strobe stays high with a stable address and write data until ready. When the memory stalls, done falls in cycle max(budget, transfer cycles + 2).
- R12: A start while busy is ignored: no second fetch and no second done.
- R13: While done is high, cycles equals the budget of the instruction's class (8, 15 or 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction (accepted when idle) |
| pc_in | input | ADDR_W | Address of the opcode byte |
| hl_in | input | ADDR_W | Memory operand address |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | CNT_W | Cycle budget of the current instruction |
| pc_out | output | ADDR_W | Incremented program counter |
| pc_we | output | 1 | Load strobe for pc_out |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ready | input | 1 | Transfer completes this cycle |
| rf_sel | output | 3 | Register select |
| rf_rdata | input | 8 | Selected register value |
| rf_we | output | 1 | Register write strobe |
| rf_wdata | output | 8 | Register write data |
| flags_in | input | 8 | Current flag byte |
| flags_out | output | 8 | New flag byte |
| flags_we | output | 1 | Flag write strobe |

## Verification
The bench uses the default parameters: a 16-bit address and budgets of 8, 15 and 12. Its memory model decodes only the low address byte, so the opcode and the HL operand sit at two fixed cells. With the opcode being only one byte, every one of the 256 codes is run against several operand patterns and both carry values, which covers every operand slot, shift kind and bit index, including the bit-7 sign path. Runs with 2 and 5 wait cycles per transfer cover both cases: the budget still dominating, and the stalled transfers pushing done beyond it.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLR   = 2'd2,
        GRP_SET   = 2'd3
    } grp_e;

    typedef enum logic [2:0] {
        SH_RLC, SH_RRC, SH_RL, SH_RR, SH_SLA, SH_SRA, SH_SLL, SH_SRL
    } shk_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_MREAD, S_OPER, S_MWRITE, S_HOLD
    } state_e;

    localparam int FL_C = 0;
    localparam int FL_N = 1;
    localparam int FL_P = 2;
    localparam int FL_H = 4;
    localparam int FL_Z = 6;
    localparam int FL_S = 7;

    localparam logic [2:0] OPND_MEM = 3'd6;

    typedef struct packed {
        grp_e       grp;
        logic [2:0] sub;
        logic [2:0] opnd;
        logic       is_mem;
    } dec_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [7:0] code,
    output dec_t       dec
);
    always_comb begin
        dec.grp    = grp_e'(code[7:6]);
        dec.sub    = code[5:3];
        dec.opnd   = code[2:0];
        dec.is_mem = (code[2:0] == OPND_MEM);
    end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
(
    input  dec_t       dec,
    input  logic [7:0] operand,
    input  logic [7:0] flags_in,
    output logic [7:0] result,
    output logic [7:0] flags_res
);
    logic [7:0] mask;
    logic       shifted_out;
    logic       tested;

    always_comb begin
        mask        = 8'h01 << dec.sub;
        tested      = operand[dec.sub];
        result      = operand;
        flags_res   = flags_in;
        shifted_out = 1'b0;
        unique case (dec.grp)
            GRP_SHIFT: begin
                unique case (shk_e'(dec.sub))
                    SH_RLC: begin result = {operand[6:0], operand[7]};    shifted_out = operand[7]; end
                    SH_RRC: begin result = {operand[0], operand[7:1]};    shifted_out = operand[0]; end
                    SH_RL:  begin result = {operand[6:0], flags_in[FL_C]}; shifted_out = operand[7]; end
                    SH_RR:  begin result = {flags_in[FL_C], operand[7:1]}; shifted_out = operand[0]; end
                    SH_SLA: begin result = {operand[6:0], 1'b0};          shifted_out = operand[7]; end
                    SH_SRA: begin result = {operand[7], operand[7:1]};    shifted_out = operand[0]; end
                    SH_SLL: begin result = {operand[6:0], 1'b1};          shifted_out = operand[7]; end
                    SH_SRL: begin result = {1'b0, operand[7:1]};          shifted_out = operand[0]; end
                endcase
                flags_res[FL_S] = result[7];
                flags_res[FL_Z] = (result == 8'h00);
                flags_res[FL_H] = 1'b0;
                flags_res[FL_P] = ~^result;
                flags_res[FL_N] = 1'b0;
                flags_res[FL_C] = shifted_out;
            end
            GRP_TEST: begin
                flags_res[FL_Z] = ~tested;
                flags_res[FL_H] = 1'b1;
                flags_res[FL_N] = 1'b0;
                flags_res[FL_S] = (dec.sub == 3'd7) & tested;
            end
            GRP_CLR: result = operand & ~mask;
            GRP_SET: result = operand | mask;
        endcase
    end
endmodule

// File: rtl/bitop_timer.sv
module bitop_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] SAT = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= CNT_W'(1);
        else if (run && count != SAT)
            count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter  int ADDR_W       = 16,
    parameter  int CYC_REG      = 8,
    parameter  int CYC_MEM_RMW  = 15,
    parameter  int CYC_MEM_TEST = 12,
    localparam int CYC_MAX = (CYC_MEM_RMW > CYC_MEM_TEST)
                           ? ((CYC_MEM_RMW > CYC_REG) ? CYC_MEM_RMW : CYC_REG)
                           : ((CYC_MEM_TEST > CYC_REG) ? CYC_MEM_TEST : CYC_REG),
    localparam int CNT_W = $clog2(CYC_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] hl_in,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  cycles,
    output logic [ADDR_W-1:0] pc_out,
    output logic              pc_we,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready,
    output logic [2:0]        rf_sel,
    input  logic [7:0]        rf_rdata,
    output logic              rf_we,
    output logic [7:0]        rf_wdata,
    input  logic [7:0]        flags_in,
    output logic [7:0]        flags_out,
    output logic              flags_we
);
    state_e            state_q, state_d;
    logic [ADDR_W-1:0] pc_q, hl_q;
    logic [7:0]        data_q;
    dec_t              dec_q, dec_f;
    logic [CNT_W-1:0]  elapsed, budget;
    logic [7:0]        alu_in, alu_res, alu_flags;
    logic              start_acc, finish, writes_back;

    bitop_decode u_dec (.code(mem_rdata), .dec(dec_f));

    bitop_alu u_alu (
        .dec(dec_q), .operand(alu_in), .flags_in(flags_in),
        .result(alu_res), .flags_res(alu_flags)
    );

    bitop_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clear(start_acc), .run(busy), .count(elapsed)
    );

    assign start_acc   = start && (state_q == S_IDLE);
    assign writes_back = dec_q.grp != GRP_TEST;
    assign alu_in      = dec_q.is_mem ? data_q : rf_rdata;
    assign budget      = !dec_q.is_mem ? CNT_W'(CYC_REG)
                       : (dec_q.grp == GRP_TEST) ? CNT_W'(CYC_MEM_TEST) : CNT_W'(CYC_MEM_RMW);
    assign finish      = elapsed >= budget;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start)     state_d = S_FETCH;
            S_FETCH:  if (mem_ready) state_d = dec_f.is_mem ? S_MREAD : S_OPER;
            S_MREAD:  if (mem_ready) state_d = S_OPER;
            S_OPER:   state_d = (dec_q.is_mem && writes_back) ? S_MWRITE : S_HOLD;
            S_MWRITE: if (mem_ready) state_d = S_HOLD;
            S_HOLD:   if (finish)    state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pc_q    <= '0;
            hl_q    <= '0;
            data_q  <= '0;
            dec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_acc) begin
                pc_q <= pc_in;
                hl_q <= hl_in;
            end
            if (state_q == S_FETCH && mem_ready) dec_q  <= dec_f;
            if (state_q == S_MREAD && mem_ready) data_q <= mem_rdata;
            if (state_q == S_OPER)               data_q <= alu_res;
        end
    end

    always_comb begin
        busy      = state_q != S_IDLE;
        done      = (state_q == S_HOLD) && finish;
        cycles    = budget;
        pc_out    = pc_q + ADDR_W'(1);
        pc_we     = (state_q == S_FETCH) && mem_ready;
        mem_rd    = (state_q == S_FETCH) || (state_q == S_MREAD);
        mem_wr    = state_q == S_MWRITE;
        mem_addr  = (state_q == S_FETCH) ? pc_q : hl_q;
        mem_wdata = data_q;
        rf_sel    = dec_q.opnd;
        rf_we     = (state_q == S_OPER) && !dec_q.is_mem && writes_back;
        rf_wdata  = alu_res;
        flags_out = alu_flags;
        flags_we  = (state_q == S_OPER) &&
                    (dec_q.grp == GRP_SHIFT || dec_q.grp == GRP_TEST);
    end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              pc_we,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              rf_we,
    input logic              flags_we
);
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!busy && !done && !mem_rd && !mem_wr)); // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
    AST_PCWE_FETCH: assert property (@(posedge clk) disable iff (!rst_n) pc_we |-> (mem_rd && mem_ready)); // R2
    AST_RF_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n) rf_we |-> !(mem_rd || mem_wr)); // R8
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R9
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R11
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr))); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R12
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (busy && !rf_we && !flags_we)); // R13
endmodule

bind bitop_unit bitop_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pc_we(pc_we), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rf_we(rf_we), .flags_we(flags_we)
);

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;
    localparam int AW = 16;
    localparam logic [AW-1:0] PC_A = 16'h1234;
    localparam logic [AW-1:0] HL_A = 16'h5678;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] pc_in = PC_A, hl_in = HL_A;
    logic busy, done, pc_we, mem_rd, mem_wr, mem_ready, rf_we, flags_we;
    logic [3:0] cycles;
    logic [AW-1:0] pc_out, mem_addr;
    logic [7:0] mem_wdata, mem_rdata, rf_rdata, rf_wdata, flags_out;
    logic [2:0] rf_sel;

    logic [7:0] regs [0:7];
    logic [7:0] mem [0:255];
    logic [7:0] flags_q;

    logic        ld_en = 1'b0;
    logic [63:0] ld_regs = '0;
    logic [7:0]  ld_flags = '0, ld_code = '0, ld_memval = '0;
    int          wait_lat = 0;
    int          stall_ctr;
    int          n_pcwe, n_wr, n_done;
    logic [AW-1:0] last_pc, last_wr_addr;

    int n_checks = 0;
    int n_fail = 0;
    int cyc_total = 0;

    always #4 clk = ~clk;

    bitop_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in), .hl_in(hl_in),
        .busy(busy), .done(done), .cycles(cycles), .pc_out(pc_out), .pc_we(pc_we),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rf_sel(rf_sel), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_wdata(rf_wdata), .flags_in(flags_q), .flags_out(flags_out),
        .flags_we(flags_we)
    );

    assign rf_rdata  = regs[rf_sel];
    assign mem_rdata = mem[mem_addr[7:0]];
    assign mem_ready = (mem_rd || mem_wr) && (stall_ctr >= wait_lat);

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (!rst_n) begin
            stall_ctr <= 0; n_pcwe <= 0; n_wr <= 0; n_done <= 0;
            last_pc <= '0; last_wr_addr <= '0;
        end else begin
            if (mem_rd || mem_wr) stall_ctr <= mem_ready ? 0 : stall_ctr + 1;
            else                  stall_ctr <= 0;
            if (pc_we) begin n_pcwe <= n_pcwe + 1; last_pc <= pc_out; end
            if (mem_wr && mem_ready) begin
                n_wr <= n_wr + 1; last_wr_addr <= mem_addr;
            end
            if (done) n_done <= n_done + 1;
        end
        if (ld_en) begin
            for (int i = 0; i < 8; i++) regs[i] <= ld_regs[i*8 +: 8];
            flags_q <= ld_flags;
            mem[PC_A[7:0]] <= ld_code;
            mem[HL_A[7:0]] <= ld_memval;
        end else begin
            if (rf_we) regs[rf_sel] <= rf_wdata;
            if (flags_we) flags_q <= flags_out;
            if (mem_wr && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pattern(input int i);
        return 8'h10 * 8'(i) + 8'h03;
    endfunction

    // Reference computed from the requirement text (R4..R7)
    task automatic model(input logic [7:0] code, input logic [7:0] v, input logic [7:0] f,
                         output logic [7:0] r, output logic [7:0] fo);
        int idx = int'(code[5:3]);
        logic c = 1'b0;
        r = v; fo = f;
        case (code[7:6])
            2'b00: begin
                case (idx)
                    0: begin r = (v << 1) | (v >> 7);          c = v[7]; end
                    1: begin r = (v >> 1) | (v << 7);          c = v[0]; end
                    2: begin r = (v << 1) | 8'(f[0]);          c = v[7]; end
                    3: begin r = (v >> 1) | (8'(f[0]) << 7);   c = v[0]; end
                    4: begin r = v << 1;                        c = v[7]; end
                    5: begin r = (v >> 1) | (v & 8'h80);       c = v[0]; end
                    6: begin r = (v << 1) | 8'h01;             c = v[7]; end
                    default: begin r = v >> 1;                  c = v[0]; end
                endcase
                fo[7] = r[7];
                fo[6] = (r == 8'h00);
                fo[4] = 1'b0;
                fo[2] = ($countones(r) % 2) == 0;
                fo[1] = 1'b0;
                fo[0] = c;
            end
            2'b01: begin
                fo[6] = ((v >> idx) & 8'h01) == 8'h00;
                fo[4] = 1'b1;
                fo[1] = 1'b0;
                fo[7] = (idx == 7) && v[7];
            end
            2'b10: r = v & ~(8'h01 << idx);
            default: r = v | (8'h01 << idx);
        endcase
    endtask

    task automatic run_op(input logic [7:0] code, input logic [7:0] val,
                          input logic [7:0] flg, input int wl, input bit extra);
        int   opnd = int'(code[2:0]);
        bit   is_mem = (opnd == 6);
        bit   is_test = (code[7:6] == 2'b01);
        int   budget, path, exp_done, cnt;
        int   p0, w0, d0;
        logic [7:0] r, fo, exp_store, act_store, cyc_seen;
        string tr, td, tf;
        bit   others_ok;

        @(negedge clk);
        for (int i = 0; i < 8; i++) ld_regs[i*8 +: 8] = (i == opnd) ? val : pattern(i);
        ld_flags  = flg;
        ld_code   = code;
        ld_memval = is_mem ? val : 8'hC3;
        wait_lat  = wl;
        ld_en     = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
        p0 = n_pcwe; w0 = n_wr; d0 = n_done;
        pc_in = PC_A; hl_in = HL_A;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 100) begin
            @(negedge clk);
            cnt++;
            start = extra && (cnt == 3);
            if (extra && cnt == 3) pc_in = 16'h00AA;
        end
        start = 1'b0;
        cyc_seen = 8'(cycles);

        model(code, val, flg, r, fo);
        if (!is_mem) begin budget = 8;  path = wl + 3; end
        else if (is_test) begin budget = 12; path = 2 * (wl + 1) + 2; end
        else begin budget = 15; path = 3 * (wl + 1) + 2; end
        exp_done = (path > budget) ? path : budget;

        td = (wl != 0) ? "R11" : (!is_mem ? "R8" : (is_test ? "R10" : "R9"));
        chk(cnt == exp_done, td, $sformatf("done cycle op %02h", code), cnt, exp_done);
        chk(cyc_seen == 8'(budget), "R13", $sformatf("cycles op %02h", code), cyc_seen, budget);
        chk(n_pcwe - p0 == 1 && last_pc == PC_A + 16'h1, "R2",
            $sformatf("pc update op %02h", code), last_pc, PC_A + 16'h1);

        case (code[7:6])
            2'b00:   begin tr = "R4"; tf = "R5"; end
            2'b01:   begin tr = "R6"; tf = "R6"; end
            default: begin tr = "R7"; tf = "R7"; end
        endcase
        exp_store = is_test ? val : r;
        act_store = is_mem ? mem[HL_A[7:0]] : regs[opnd];
        chk(act_store == exp_store, tr, $sformatf("result op %02h in %02h", code, val), act_store, exp_store);
        chk(flags_q == fo, tf, $sformatf("flags op %02h in %02h f %02h", code, val, flg), flags_q, fo);

        others_ok = 1'b1;
        for (int i = 0; i < 8; i++)
            if (i != 6 && i != opnd && regs[i] != pattern(i)) others_ok = 1'b0;
        chk(others_ok, "R3", $sformatf("untouched registers op %02h", code), others_ok, 1);

        if (is_mem && !is_test)
            chk(n_wr - w0 == 1 && last_wr_addr == HL_A, "R9",
                $sformatf("write at HL op %02h", code), last_wr_addr, HL_A);
        else
            chk(n_wr - w0 == 0, is_test && is_mem ? "R10" : "R8",
                $sformatf("no memory write op %02h", code), n_wr - w0, 0);

        if (extra) begin
            repeat (4) @(negedge clk);
            chk(!busy && n_done - d0 == 1 && n_pcwe - p0 == 1, "R12",
                "start while busy ignored", n_done - d0, 1);
        end
    endtask

    initial begin
        logic [7:0] vals [0:3];
        vals[0] = 8'h00; vals[1] = 8'h81; vals[2] = 8'hFF; vals[3] = 8'h5A;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr && !rf_we && !flags_we && !pc_we,
            "R1", "reset state", {busy, done, mem_rd, mem_wr, rf_we, flags_we, pc_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1", "idle after reset release", {busy, done}, 0);

        for (int code = 0; code < 256; code++)
            for (int vi = 0; vi < 4; vi++) begin
                run_op(8'(code), vals[vi], 8'h28, 0, 1'b0);
                run_op(8'(code), vals[vi], 8'h01, 0, 1'b0);
            end

        // R11: stalled memory with two latencies across classes
        for (int wl = 2; wl <= 5; wl += 3) begin
            run_op(8'h06, 8'h81, 8'h00, wl, 1'b0);
            run_op(8'h7E, 8'h81, 8'h00, wl, 1'b0);
            run_op(8'h47, 8'h81, 8'h00, wl, 1'b0);
            run_op(8'hC6, 8'h10, 8'h00, wl, 1'b0);
        end

        // R12: extra start pulses during register and memory runs
        run_op(8'h38, 8'hF0, 8'h00, 0, 1'b1);
        run_op(8'h9E, 8'hFF, 8'h00, 0, 1'b1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cyc_total >= 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc_total, 190000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule